// File: doc/BRIEF.md
# SPI NOR Flash Command Decoder and Status Register

This block sits on the slave side of a serial NOR flash. It sits behind a serial shifter, which is not part of the block. The shifter hands over each received byte as a one-cycle `rx_valid` strobe with `rx_byte`. The active-low chip select `cs_n` frames a transaction. The first byte of a frame is an opcode. A frame may carry several opcodes one after another: a command that takes only its opcode byte, or a status write with its single data byte, returns the decoder to opcode expectation within the same frame. The byte the shifter should send next is offered on `tx_byte`.

The block owns the write-enable latch, a six-bit writable status field and the addressing-width mode. The top bit of the status field is a sticky status-write-disable bit. Together with the active-low write-protect pin `wp_n`, it can lock the status register. Program, sector erase and bulk erase are granted only with the latch set, and a grant consumes the latch. A grant is reported to the array side as `wr_allow`, or as a one-cycle `erase_req`. A read reports `read_active`. Both carry the collected address on `op_addr`.

The controller state machine has the states S_CMD (awaiting an opcode), S_WRSR_DATA (awaiting the status data byte), S_STAT_RD (returning status), S_ID_RD (returning the identification bytes), S_ADDR (collecting address bytes), S_PGM_DATA (program data phase), S_RD_DATA (read data phase) and S_SKIP (rest of frame ignored). The transitions are as follows:
- Any state goes to S_CMD when `cs_n` is high.
- S_CMD goes to S_STAT_RD on 0x05, to S_WRSR_DATA on 0x01 and to S_ID_RD on 0x9F.
- S_CMD goes to S_ADDR on 0x03, and on 0x02 or 0xD8 while the latch is set.
- S_CMD goes to S_SKIP on a rejected 0x02 or 0xD8, and on any undecoded opcode.
- S_CMD stays in S_CMD on the single-byte opcodes.
- S_WRSR_DATA returns to S_CMD after its data byte.
- S_ADDR leaves after its last address byte: to S_RD_DATA for a read, to S_PGM_DATA for a program, and to S_SKIP for a sector erase.

Top module: `spi_flash_status_ctl`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the latch is clear after reset.
- R2: After opcode 0x05, every further byte slot of the frame offers the live status byte on `tx_byte`: bit 7 the write-disable bit, bits 6:2 the protect field, bit 1 the write-enable latch, bit 0 zero. Outside read phases `tx_byte` is 0xFF.
- R3: Commands chain inside one frame. A 0x06 followed directly by 0x05 reports the latch set. Raising `cs_n` aborts any command, and the next frame's first byte is decoded as an opcode.
- R4: Opcode 0x01 loads bits 7:2 of the next byte into the status field when the latch is set and the lock condition is absent; bits 1:0 of that byte are ignored. An accepted status write clears the latch.
- R5: A status write is ignored, leaving the status field and latch unchanged, when `wp_n` is low and bit 7 is set, or when the latch is clear.
- R6: Opcode 0x9F returns the ID_CODE bytes most significant first, then 0x00 for any further slots.
- R7: Opcode 0x66 immediately followed by opcode 0x99 clears the latch and the 4-byte mode and keeps the status field. A 0x99 whose preceding opcode was not 0x66 has no effect.
- R8: Opcode 0xB7 selects 4-byte addressing. Address bytes arrive most significant first, 3 of them (upper byte of `op_addr` zero) or 4 in that mode.
- R9: Opcode 0x03 needs no latch. After its last address byte, `read_active` is high with `op_addr` until `cs_n` rises.
- R10: Opcode 0x02 with the latch set clears the latch. After its address, `wr_allow` is high with `op_addr` until `cs_n` rises.
- R11: Opcode 0xD8 with the latch set pulses `erase_req` for one cycle after its last address byte, with `erase_all` low. Opcode 0xC7 with the latch set pulses `erase_req` after the opcode, with `erase_all` high. Both clear the latch.
- R12: Program and erase opcodes with the latch clear are rejected: no `wr_allow`, no `erase_req`, and the rest of a rejected 0x02/0xD8 frame is ignored.
- R13: An undecoded opcode makes the rest of its frame ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, frames a transaction |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| tx_byte | output | 8 | Byte to shift out in the next slot |
| wr_allow | output | 1 | Program data phase granted |
| read_active | output | 1 | Read data phase active |
| erase_req | output | 1 | One-cycle erase grant |
| erase_all | output | 1 | Qualifies erase_req: whole array |
| op_addr | output | ADDR_W | Collected address of the current operation |

## Verification
On every cycle, the assertions check the following:
- the latch follows set, clear and consume events;
- a locked status write leaves the field unchanged;
- the reset sequence keeps the protect field;
- `cs_n` high sends the controller back to opcode state;
- the grant outputs are mutually exclusive, with `erase_req` lasting one cycle.

Only the bench's scenarios can show the values seen at the byte interface. These include the status byte composition, the ID byte order, the 3- versus 4-byte address lengths and the assembled `op_addr`. They also include the four combinations of pin and disable bit, and the randomly interleaved command streams checked against a reference model.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RSTEN = 8'h66;
    localparam logic [7:0] OP_RST   = 8'h99;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_EN4B  = 8'hB7;
    localparam logic [7:0] OP_CE    = 8'hC7;
    localparam logic [7:0] OP_SE    = 8'hD8;

    typedef enum logic [2:0] {
        S_CMD,
        S_WRSR_DATA,
        S_STAT_RD,
        S_ID_RD,
        S_ADDR,
        S_PGM_DATA,
        S_RD_DATA,
        S_SKIP
    } fsm_state_t;

    typedef enum logic [1:0] {
        K_READ,
        K_PGM,
        K_SERASE
    } addr_kind_t;

    typedef struct packed {
        logic op;       // an opcode byte was taken
        logic wren;
        logic wrdi;
        logic en4b;
        logic rst_en;
        logic rst;      // armed reset executes
        logic wrsr;     // status data byte taken
        logic pe_take;  // program/erase granted, consumes latch
    } stat_ev_t;

endpackage

// File: rtl/spi_status_reg.sv
module spi_status_reg
    import spi_flash_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  stat_ev_t ev,
    input  logic [7:0] wrsr_data,
    input  logic     wp_n,
    output logic     wel,
    output logic     four_byte,
    output logic     rst_armed,
    output logic [7:0] status_byte
);
    localparam int FIELD_W = 6;

    logic [FIELD_W-1:0] field_q;
    logic               locked;
    logic               wrsr_ok;

    assign locked  = !wp_n && field_q[FIELD_W-1];
    assign wrsr_ok = ev.wrsr && wel && !locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            four_byte <= 1'b0;
            rst_armed <= 1'b0;
            field_q   <= '0;
        end else begin
            if (ev.op)
                rst_armed <= ev.rst_en;
            if (ev.wren)
                wel <= 1'b1;
            else if (ev.wrdi || ev.pe_take || wrsr_ok || ev.rst)
                wel <= 1'b0;
            if (ev.en4b)
                four_byte <= 1'b1;
            else if (ev.rst)
                four_byte <= 1'b0;
            if (wrsr_ok)
                field_q <= wrsr_data[7:2];
        end
    end

    assign status_byte = {field_q, wel, 1'b0};

    assert_wren_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev.wren |=> wel);
    assert_wrdi_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev.wrdi |=> !wel);
    assert_locked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.wrsr && !wp_n && field_q[FIELD_W-1]) |=> $stable(field_q));
    assert_wrsr_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.wrsr && !wel) |=> $stable(field_q) && !wel);
    assert_reset_keeps_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rst |=> !wel && !four_byte && $stable(field_q));
    assert_grant_consumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev.pe_take |=> !wel);

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              wel,
    input  logic              four_byte,
    input  logic              rst_armed,
    output fsm_state_t        state,
    output logic [$clog2(ID_BYTES+1)-1:0] id_idx,
    output stat_ev_t          ev,
    output logic              wr_allow,
    output logic              read_active,
    output logic              erase_req,
    output logic              erase_all,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int IDX_W = $clog2(ID_BYTES+1);

    fsm_state_t nxt;
    addr_kind_t kind_q;
    logic [2:0] addr_len_q;
    logic [2:0] addr_cnt_q;
    logic       take;
    logic       addr_last;
    logic       is_pe_op;

    assign take      = rx_valid && !cs_n;
    assign addr_last = (addr_cnt_q == addr_len_q - 3'd1);
    assign is_pe_op  = (rx_byte == OP_PP) || (rx_byte == OP_SE) || (rx_byte == OP_CE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CMD;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = S_CMD;
        end else if (rx_valid) begin
            unique case (state)
                S_CMD: begin
                    case (rx_byte)
                        OP_RDSR:  nxt = S_STAT_RD;
                        OP_WRSR:  nxt = S_WRSR_DATA;
                        OP_RDID:  nxt = S_ID_RD;
                        OP_READ:  nxt = S_ADDR;
                        OP_PP, OP_SE: nxt = wel ? S_ADDR : S_SKIP;
                        OP_WREN, OP_WRDI, OP_EN4B,
                        OP_RSTEN, OP_RST, OP_CE: nxt = S_CMD;
                        default:  nxt = S_SKIP;
                    endcase
                end
                S_WRSR_DATA: nxt = S_CMD;
                S_ADDR: begin
                    if (addr_last) begin
                        unique case (kind_q)
                            K_READ:   nxt = S_RD_DATA;
                            K_PGM:    nxt = S_PGM_DATA;
                            default:  nxt = S_SKIP;
                        endcase
                    end
                end
                S_STAT_RD, S_ID_RD, S_PGM_DATA, S_RD_DATA, S_SKIP: nxt = state;
            endcase
        end
    end

    // events towards the status register
    always_comb begin
        ev = '0;
        if (take) begin
            if (state == S_CMD) begin
                ev.op      = 1'b1;
                ev.wren    = (rx_byte == OP_WREN);
                ev.wrdi    = (rx_byte == OP_WRDI);
                ev.en4b    = (rx_byte == OP_EN4B);
                ev.rst_en  = (rx_byte == OP_RSTEN);
                ev.rst     = (rx_byte == OP_RST) && rst_armed;
                ev.pe_take = is_pe_op && wel;
            end else if (state == S_WRSR_DATA) begin
                ev.wrsr = 1'b1;
            end
        end
    end

    // operation datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_READ;
            addr_len_q <= 3'd3;
            addr_cnt_q <= '0;
            op_addr    <= '0;
            id_idx     <= '0;
            erase_req  <= 1'b0;
            erase_all  <= 1'b0;
        end else begin
            erase_req <= 1'b0;
            if (take && state == S_CMD) begin
                id_idx     <= '0;
                addr_cnt_q <= '0;
                addr_len_q <= four_byte ? 3'd4 : 3'd3;
                case (rx_byte)
                    OP_PP:   kind_q <= K_PGM;
                    OP_SE:   kind_q <= K_SERASE;
                    default: kind_q <= K_READ;
                endcase
                if (rx_byte == OP_READ || rx_byte == OP_PP || rx_byte == OP_SE)
                    op_addr <= '0;
                if (rx_byte == OP_CE && wel) begin
                    erase_req <= 1'b1;
                    erase_all <= 1'b1;
                    op_addr   <= '0;
                end
            end else if (take && state == S_ADDR) begin
                op_addr    <= {op_addr[ADDR_W-9:0], rx_byte};
                addr_cnt_q <= addr_cnt_q + 3'd1;
                if (addr_last && kind_q == K_SERASE) begin
                    erase_req <= 1'b1;
                    erase_all <= 1'b0;
                end
            end else if (take && state == S_ID_RD && id_idx < IDX_W'(ID_BYTES)) begin
                id_idx <= id_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_allow    = (state == S_PGM_DATA);
        read_active = (state == S_RD_DATA);
    end

    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == S_CMD) && !wr_allow && !read_active);
    assert_grants_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_allow, read_active, erase_req}));
    assert_erase_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);
    assert_reject_pe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == S_CMD && is_pe_op && !wel) |=> !erase_req && state != S_ADDR);

endmodule

// File: rtl/spi_tx_mux.sv
module spi_tx_mux
    import spi_flash_pkg::*;
#(
    parameter int ID_BYTES = 3,
    parameter logic [8*ID_BYTES-1:0] ID_CODE = '0
) (
    input  fsm_state_t state,
    input  logic [$clog2(ID_BYTES+1)-1:0] id_idx,
    input  logic [7:0] status_byte,
    output logic [7:0] tx_byte
);
    logic [7:0] id_byte;

    always_comb begin
        id_byte = 8'h00;
        for (int i = 0; i < ID_BYTES; i++) begin
            if (int'(id_idx) == i)
                id_byte = ID_CODE[8*(ID_BYTES-1-i) +: 8];
        end
    end

    always_comb begin
        unique case (state)
            S_STAT_RD: tx_byte = status_byte;
            S_ID_RD:   tx_byte = id_byte;
            S_CMD, S_WRSR_DATA, S_ADDR, S_PGM_DATA, S_RD_DATA, S_SKIP:
                       tx_byte = 8'hFF;
        endcase
    end

endmodule

// File: rtl/spi_flash_status_ctl.sv
module spi_flash_status_ctl
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_BYTES = 3,
    parameter logic [8*ID_BYTES-1:0] ID_CODE = 24'h5AA53C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              wp_n,
    output logic [7:0]        tx_byte,
    output logic              wr_allow,
    output logic              read_active,
    output logic              erase_req,
    output logic              erase_all,
    output logic [ADDR_W-1:0] op_addr
);
    fsm_state_t state;
    stat_ev_t   ev;
    logic       wel, four_byte, rst_armed;
    logic [7:0] status_byte;
    logic [$clog2(ID_BYTES+1)-1:0] id_idx;

    spi_cmd_fsm #(.ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wel(wel), .four_byte(four_byte),
        .rst_armed(rst_armed), .state(state), .id_idx(id_idx), .ev(ev),
        .wr_allow(wr_allow), .read_active(read_active),
        .erase_req(erase_req), .erase_all(erase_all), .op_addr(op_addr)
    );

    spi_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev), .wrsr_data(rx_byte), .wp_n(wp_n),
        .wel(wel), .four_byte(four_byte), .rst_armed(rst_armed),
        .status_byte(status_byte)
    );

    spi_tx_mux #(.ID_BYTES(ID_BYTES), .ID_CODE(ID_CODE)) u_tx (
        .state(state), .id_idx(id_idx), .status_byte(status_byte),
        .tx_byte(tx_byte)
    );

endmodule

// File: tb/spi_flash_status_ctl_tb.sv
module spi_flash_status_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic wp_n = 1'b1;
    logic [7:0] tx_byte;
    logic wr_allow, read_active, erase_req, erase_all;
    logic [31:0] op_addr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    logic       m_wel;
    logic [5:0] m_sr;
    logic       m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_status_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wp_n(wp_n), .tx_byte(tx_byte),
        .wr_allow(wr_allow), .read_active(read_active),
        .erase_req(erase_req), .erase_all(erase_all), .op_addr(op_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic fstart();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic fend();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n  = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        m_wel = 1'b0; m_sr = '0; m_armed = 1'b0;
    endtask

    function automatic logic [7:0] exp_status();
        return {m_sr, m_wel, 1'b0};
    endfunction

    // read status in a fresh frame and compare
    task automatic rd_status(string tag, logic [7:0] exp);
        fstart();
        send(8'h05);
        chk(tag, {24'd0, tx_byte}, {24'd0, exp});
        fend();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R2 idle tx
        chk("R2 reset tx", {24'd0, tx_byte}, 32'hFF);
        chk("R9 reset outputs", {28'd0, wr_allow, read_active, erase_req, erase_all}, 0);
        rd_status("R1 reset latch clear", 8'h00);

        // R1 / R3: chaining in one frame, continuous status
        fstart(); send(8'h06); send(8'h05);
        chk("R3 wren then rdsr", {24'd0, tx_byte}, 32'h02);
        send(8'h00);
        chk("R2 continuous status", {24'd0, tx_byte}, 32'h02);
        fend();
        fstart(); send(8'h04); send(8'h05);
        chk("R1 wrdi clears", {24'd0, tx_byte}, 32'h00);
        fend();

        // R3: abort mid-command, next frame opcode
        fstart(); send(8'h01); fend();
        fstart(); send(8'h06); fend();
        rd_status("R3 abort then opcode", 8'h02);

        // R4 / R5 protection matrix
        fstart(); send(8'h01); send(8'h80); send(8'h05);
        chk("R4 write-enable latch set accepted", {24'd0, tx_byte}, 32'h80);
        fend();
        fstart(); send(8'h06); send(8'h01); send(8'h00); send(8'h05);
        chk("R4 pin high bit set writable", {24'd0, tx_byte}, 32'h00);
        fend();
        wp_n = 1'b0;
        fstart(); send(8'h06); send(8'h01); send(8'h80); send(8'h05);
        chk("R4 pin low bit clear writable", {24'd0, tx_byte}, 32'h80);
        fend();
        fstart(); send(8'h06); send(8'h01); send(8'h00); send(8'h05);
        chk("R5 pin low bit set locked", {24'd0, tx_byte}, 32'h82);
        fend();
        wp_n = 1'b1;
        fstart(); send(8'h04); send(8'h01); send(8'h00); send(8'h05);
        chk("R5 latch clear ignored", {24'd0, tx_byte}, 32'h80);
        fend();
        fstart(); send(8'h06); send(8'h01); send(8'h1F); send(8'h05);
        chk("R4 low bits ignored", {24'd0, tx_byte}, 32'h1C);
        fend();

        // R6 ID read
        fstart(); send(8'h9F);
        chk("R6 id byte0", {24'd0, tx_byte}, 32'h5A);
        send(8'h00); chk("R6 id byte1", {24'd0, tx_byte}, 32'hA5);
        send(8'h00); chk("R6 id byte2", {24'd0, tx_byte}, 32'h3C);
        send(8'h00); chk("R6 id past end", {24'd0, tx_byte}, 32'h00);
        fend();

        // R8 / R9: 4-byte read
        fstart(); send(8'hB7); send(8'h03);
        send(8'h12); send(8'h34); send(8'h56);
        chk("R8 four-byte not after 3", {31'd0, read_active}, 0);
        send(8'h78);
        chk("R9 read active", {31'd0, read_active}, 1);
        chk("R8 four-byte addr", op_addr, 32'h12345678);
        fend();
        chk("R9 read ends on cs", {31'd0, read_active}, 0);

        // R7 reset sequence keeps field (0x1C), clears latch and 4-byte mode
        fstart(); send(8'h06); send(8'h66); send(8'h99); send(8'h05);
        chk("R7 reset keeps field", {24'd0, tx_byte}, 32'h1C);
        fend();
        fstart(); send(8'h03); send(8'hAB); send(8'hCD); send(8'hEF);
        chk("R8 three-byte addr", op_addr, 32'h00ABCDEF);
        chk("R7 four-byte cleared", {31'd0, read_active}, 1);
        fend();
        fstart(); send(8'h06); send(8'h99); send(8'h05);
        chk("R7 lone 99 no effect", {24'd0, tx_byte}, 32'h1E);
        fend();
        fstart(); send(8'h66); send(8'h06); send(8'h99); send(8'h05);
        chk("R7 interrupted sequence", {24'd0, tx_byte}, 32'h1E);
        fend();

        // R10 program with latch
        fstart(); send(8'h02);
        send(8'h01); send(8'h02);
        chk("R10 not yet", {31'd0, wr_allow}, 0);
        send(8'h03);
        chk("R10 wr_allow", {31'd0, wr_allow}, 1);
        chk("R10 addr", op_addr, 32'h00010203);
        send(8'h55);
        chk("R10 data phase holds", {31'd0, wr_allow}, 1);
        fend();
        chk("R10 drop on cs", {31'd0, wr_allow}, 0);
        rd_status("R10 latch consumed", 8'h1C);

        // R12 rejected program and erase
        fstart(); send(8'h02); send(8'h00); send(8'h00); send(8'h00);
        chk("R12 program rejected", {31'd0, wr_allow}, 0);
        send(8'h06); send(8'h05);
        chk("R12 rest ignored", {24'd0, tx_byte}, 32'hFF);
        fend();
        fstart(); send(8'hC7);
        chk("R12 bulk erase rejected", {31'd0, erase_req}, 0);
        fend();

        // R11 sector erase and bulk erase
        fstart(); send(8'h06); send(8'hD8); send(8'h00); send(8'h04);
        chk("R11 no early erase", {31'd0, erase_req}, 0);
        send(8'h00);
        chk("R11 sector erase pulse", {30'd0, erase_req, erase_all}, 32'h2);
        chk("R11 sector addr", op_addr, 32'h00000400);
        @(negedge clk);
        chk("R11 single pulse", {31'd0, erase_req}, 0);
        fend();
        fstart(); send(8'h06); send(8'hC7);
        chk("R11 bulk erase pulse", {30'd0, erase_req, erase_all}, 32'h3);
        send(8'h05);
        chk("R11 latch consumed", {24'd0, tx_byte}, 32'h1C);
        fend();

        // R13 unknown opcode
        fstart(); send(8'h42); send(8'h06); send(8'h05);
        chk("R13 ignored tx", {24'd0, tx_byte}, 32'hFF);
        fend();
        rd_status("R13 latch untouched", 8'h1C);

        // constrained random streams against the model
        do_reset();
        void'($urandom(32'd20240607));
        for (int it = 0; it < 400; it++) begin
            int ncmd;
            fstart();
            ncmd = 1 + int'($urandom % 4);
            for (int k = 0; k < ncmd; k++) begin
                int r;
                r = int'($urandom % 8);
                case (r)
                    0: begin send(8'h06); m_wel = 1'b1; m_armed = 1'b0; end
                    1: begin send(8'h04); m_wel = 1'b0; m_armed = 1'b0; end
                    2: begin
                        logic [7:0] d;
                        d = 8'($urandom);
                        send(8'h01); m_armed = 1'b0;
                        send(d);
                        if (m_wel && !(!wp_n && m_sr[5])) begin
                            m_sr = d[7:2]; m_wel = 1'b0;
                        end
                    end
                    3: begin send(8'hB7); m_armed = 1'b0; end
                    4: begin send(8'h66); m_armed = 1'b1; end
                    5: begin
                        send(8'h99);
                        if (m_armed) m_wel = 1'b0;
                        m_armed = 1'b0;
                    end
                    6: begin
                        send(8'hC7);
                        chk("R11 random bulk erase", {31'd0, erase_req}, {31'd0, m_wel});
                        m_wel = 1'b0; m_armed = 1'b0;
                    end
                    default: wp_n = 1'($urandom);
                endcase
            end
            send(8'h05); m_armed = 1'b0;
            chk("R4 random status", {24'd0, tx_byte}, {24'd0, exp_status()});
            fend();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule